// File: doc/BRIEF.md
# Two-Read One-Write Register File

This block is the general-purpose register storage of a small processor datapath. It holds 32 words of 32 bits. Two read ports return data combinationally, each from its own 5-bit address, so an operand pair is available in the same cycle the addresses are presented. A single write port stores a word on the rising clock edge when its enable is high.

The top index (31) is a constant-zero register. It reads as zero on either port, and any write aimed at it is dropped, so software can use it as a zero source or as a discard target. A read of the address being written in the same cycle shows the value held before the edge, because there is no write-through path. The stored words are not cleared by reset. While the synchronous active-high reset is held, the write port is blocked so that a processor still in reset cannot corrupt state.

Top module: `dual_read_regfile`

## Requirements
- R1: Addresses are 5-bit unsigned binary indices 0..31. When `wr_en` is high and `rst` is low at a rising edge, `wr_data` is stored at `wr_addr`, and a read of that index returns it from the following cycle on.
- R2: The two read ports are independent: in one cycle port A and port B may address different registers and each returns its own register's value.
- R3: Read data is combinational. A change of a read address between clock edges updates that port's data in the same cycle, with no edge in between.
- R4: When a read address equals `wr_addr` during a write cycle, that port shows the value from before the edge until the edge has passed (no bypass).
- R5: A read of index 31 returns all zeros on either port at all times, including during reset.
- R6: A write with `wr_addr` = 31 changes no register, and index 31 still reads as zero afterwards.
- R7: With `wr_en` low, no register changes, whatever `wr_addr` and `wr_data` hold.
- R8: While `rst` is high, writes are blocked. Reset does not clear the stored words: values written before reset are still read after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes happen on the rising edge |
| rst | input | 1 | Synchronous active-high reset; blocks writes, leaves contents intact |
| rd_addr_a | input | 5 | Read port A index |
| rd_data_a | output | 32 | Read port A data, combinational |
| rd_addr_b | input | 5 | Read port B index |
| rd_data_b | output | 32 | Read port B data, combinational |
| wr_addr | input | 5 | Write index |
| wr_data | input | 32 | Write data |
| wr_en | input | 1 | Write enable |

## Verification
Read data is due in the same cycle as its address, and a write becomes visible only in the cycle after the rising edge that stores it. The driver therefore changes inputs on the falling edge and queues the value a read should show before the coming rising edge. The monitor compares that value two nanoseconds later, still ahead of the rising edge. The bench's model updates only after the rising edge, so a collision read is expected to show the old word. Each following read then expects whatever the write, dropped write, disabled write or reset-blocked write should have left behind.

// File: rtl/regfile_pkg.sv
package regfile_pkg;
  localparam int unsigned RF_DATA_W_DEF = 32;
  localparam int unsigned RF_ADDR_W_DEF = 5;

  function automatic int unsigned rf_depth(input int unsigned addr_w);
    return 32'd1 << addr_w;
  endfunction
endpackage

// File: rtl/rf_wr_decode.sv
module rf_wr_decode #(
  parameter int unsigned ADDR_W = regfile_pkg::RF_ADDR_W_DEF,
  localparam int unsigned DEPTH = regfile_pkg::rf_depth(ADDR_W),
  localparam int unsigned ZERO_IDX = DEPTH - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic [DEPTH-1:0]  wr_strobe
);
  localparam logic [ADDR_W-1:0] ZERO_ADDR = ADDR_W'(ZERO_IDX);

  logic wr_live;
  assign wr_live = wr_en && !rst && (wr_addr != ZERO_ADDR);

  always_comb begin
    wr_strobe = '0;
    if (wr_live) wr_strobe[wr_addr] = 1'b1;
  end

  // R1
  strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_strobe));

  // R6
  zero_never_strobed_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_addr == ZERO_ADDR) |-> (wr_strobe == '0));

  // R7
  idle_no_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en |-> ($countones(wr_strobe) == 0));
endmodule

// File: rtl/rf_store.sv
module rf_store #(
  parameter int unsigned DATA_W = regfile_pkg::RF_DATA_W_DEF,
  parameter int unsigned ADDR_W = regfile_pkg::RF_ADDR_W_DEF,
  localparam int unsigned DEPTH = regfile_pkg::rf_depth(ADDR_W),
  localparam int unsigned ZERO_IDX = DEPTH - 1
) (
  input  logic                         clk,
  input  logic [DEPTH-1:0]             wr_strobe,
  input  logic [DATA_W-1:0]            wr_data,
  output logic [DEPTH-1:0][DATA_W-1:0] bank
);
  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_word
    if (gi == ZERO_IDX) begin : g_const
      assign bank[gi] = '0;
    end else begin : g_flop
      logic [DATA_W-1:0] word_q;
      always_ff @(posedge clk) begin
        if (wr_strobe[gi]) word_q <= wr_data;
      end
      assign bank[gi] = word_q;
    end
  end
endmodule

// File: rtl/rf_read_port.sv
module rf_read_port #(
  parameter int unsigned DATA_W = regfile_pkg::RF_DATA_W_DEF,
  parameter int unsigned ADDR_W = regfile_pkg::RF_ADDR_W_DEF,
  localparam int unsigned DEPTH = regfile_pkg::rf_depth(ADDR_W),
  localparam int unsigned ZERO_IDX = DEPTH - 1
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [DEPTH-1:0][DATA_W-1:0] bank,
  input  logic [ADDR_W-1:0]            rd_addr,
  output logic [DATA_W-1:0]            rd_data
);
  localparam logic [ADDR_W-1:0] ZERO_ADDR = ADDR_W'(ZERO_IDX);

  always_comb begin
    if (rd_addr == ZERO_ADDR) rd_data = '0;
    else                      rd_data = bank[rd_addr];
  end

  // R5
  zero_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_addr == ZERO_ADDR) |-> (rd_data == '0));
endmodule

// File: rtl/dual_read_regfile.sv
module dual_read_regfile #(
  parameter int unsigned DATA_W = regfile_pkg::RF_DATA_W_DEF,
  parameter int unsigned ADDR_W = regfile_pkg::RF_ADDR_W_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] rd_addr_a,
  output logic [DATA_W-1:0] rd_data_a,
  input  logic [ADDR_W-1:0] rd_addr_b,
  output logic [DATA_W-1:0] rd_data_b,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_en
);
  localparam int unsigned DEPTH = regfile_pkg::rf_depth(ADDR_W);
  localparam int unsigned ZERO_IDX = DEPTH - 1;
  localparam int unsigned N_RD = 2;
  localparam logic [ADDR_W-1:0] ZERO_ADDR = ADDR_W'(ZERO_IDX);

  logic [DEPTH-1:0]             wr_strobe;
  logic [DEPTH-1:0][DATA_W-1:0] bank;
  logic [N_RD-1:0][ADDR_W-1:0]  rd_addr_v;
  logic [N_RD-1:0][DATA_W-1:0]  rd_data_v;

  assign rd_addr_v[0] = rd_addr_a;
  assign rd_addr_v[1] = rd_addr_b;
  assign rd_data_a    = rd_data_v[0];
  assign rd_data_b    = rd_data_v[1];

  rf_wr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_strobe(wr_strobe)
  );

  rf_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
    .clk(clk), .wr_strobe(wr_strobe), .wr_data(wr_data), .bank(bank)
  );

  for (genvar gp = 0; gp < N_RD; gp++) begin : g_rd
    rf_read_port #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_port (
      .clk(clk), .rst(rst), .bank(bank),
      .rd_addr(rd_addr_v[gp]), .rd_data(rd_data_v[gp])
    );
  end

  // R1
  write_lands_a_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr != ZERO_ADDR) |=>
      ((rd_addr_a != $past(wr_addr)) || (rd_data_a == $past(wr_data))));

  // R1
  write_lands_b_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr != ZERO_ADDR) |=>
      ((rd_addr_b != $past(wr_addr)) || (rd_data_b == $past(wr_data))));

  // R7
  idle_hold_a_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ((rd_addr_a != $past(rd_addr_a)) || $stable(rd_data_a)));

  // R7
  idle_hold_b_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ((rd_addr_b != $past(rd_addr_b)) || $stable(rd_data_b)));
endmodule

// File: tb/tb_dual_read_regfile.sv
`timescale 1ns/1ps
module tb_dual_read_regfile;
  localparam int unsigned DW = 32;
  localparam int unsigned AW = 5;
  localparam logic [AW-1:0] ZR = 5'd31;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] rd_addr_a = '0, rd_addr_b = '0, wr_addr = '0;
  logic [DW-1:0] rd_data_a, rd_data_b, wr_data = '0;
  logic          wr_en = 1'b0;

  always #4 clk = ~clk;

  dual_read_regfile #(.DATA_W(DW), .ADDR_W(AW)) dut (
    .clk(clk), .rst(rst),
    .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
    .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_en(wr_en)
  );

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] mdl [32];
  logic [DW-1:0] q_a [$];
  logic [DW-1:0] q_b [$];
  string         q_tag [$];
  event          ev_sample;

  function automatic logic [DW-1:0] expect_rd(input logic [AW-1:0] a);
    return (a == ZR) ? '0 : mdl[a];
  endfunction

  // Monitor: pops each queued expectation and compares it mid-cycle.
  initial begin
    forever begin
      @(ev_sample);
      #2;
      begin
        logic [DW-1:0] ea, eb;
        string t;
        ea = q_a.pop_front();
        eb = q_b.pop_front();
        t  = q_tag.pop_front();
        checks += 2;
        if (rd_data_a !== ea) begin
          errors++;
          $display("FAIL %s port A: actual %h expected %h", t, rd_data_a, ea);
        end
        if (rd_data_b !== eb) begin
          errors++;
          $display("FAIL %s port B: actual %h expected %h", t, rd_data_b, eb);
        end
      end
    end
  end

  // Driver: one cycle of stimulus, expectation pushed before the edge.
  task automatic step(input logic rs, input logic we, input logic [AW-1:0] wa,
                      input logic [DW-1:0] wd, input logic [AW-1:0] ra,
                      input logic [AW-1:0] rb, input string tag, input bit chk);
    @(negedge clk);
    rst = rs; wr_en = we; wr_addr = wa; wr_data = wd;
    rd_addr_a = ra; rd_addr_b = rb;
    if (chk) begin
      q_a.push_back(expect_rd(ra));
      q_b.push_back(expect_rd(rb));
      q_tag.push_back(tag);
      ->ev_sample;
    end
    @(posedge clk);
    if (we && !rs && wa != ZR) mdl[wa] = wd;
  endtask

  // R3: move read addresses between edges and check both values in one cycle.
  task automatic mid_cycle_swap(input logic [AW-1:0] x, input logic [AW-1:0] y);
    @(negedge clk);
    wr_en = 1'b0; rd_addr_a = x; rd_addr_b = y;
    #1;
    rd_addr_a = y; rd_addr_b = x;
    q_a.push_back(expect_rd(y));
    q_b.push_back(expect_rd(x));
    q_tag.push_back("R3 swap between edges");
    ->ev_sample;
    @(posedge clk);
  endtask

  initial begin
    #(8 * 20000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) mdl[i] = '0;
    // R5: zero register during reset.
    step(1'b1, 1'b0, 5'd0, '0, ZR, ZR, "R5 zero in reset", 1'b1);
    step(1'b1, 1'b0, 5'd0, '0, ZR, ZR, "R5 zero in reset", 1'b1);
    // R1: fill every writable register.
    for (int i = 0; i < 31; i++)
      step(1'b0, 1'b1, AW'(i), 32'hA500_0000 ^ (i * 32'h0101_0101) ^ 32'(i),
           ZR, ZR, "R5 zero while filling", 1'b1);
    // R1 R2: different registers on the two ports.
    for (int i = 0; i < 31; i++)
      step(1'b0, 1'b0, 5'd0, '0, AW'(i), AW'(30 - i), "R1 R2 readback", 1'b1);
    mid_cycle_swap(5'd4, 5'd22);
    mid_cycle_swap(5'd0, 5'd30);
    // R4: collision shows old word; next cycle shows new word.
    step(1'b0, 1'b1, 5'd7, 32'h1234_5678, 5'd7, 5'd7, "R4 collision old value", 1'b1);
    step(1'b0, 1'b0, 5'd0, '0, 5'd7, 5'd6, "R1 new value after collision", 1'b1);
    step(1'b0, 1'b1, 5'd0, 32'hCAFE_0000, 5'd0, 5'd30, "R4 collision port A", 1'b1);
    step(1'b0, 1'b1, 5'd30, 32'h0BAD_F00D, 5'd0, 5'd30, "R4 collision port B", 1'b1);
    step(1'b0, 1'b0, 5'd0, '0, 5'd0, 5'd30, "R1 both updates seen", 1'b1);
    // R6: write to register 31 is dropped.
    step(1'b0, 1'b1, ZR, 32'hFFFF_FFFF, ZR, 5'd1, "R6 write to zero reg", 1'b1);
    step(1'b0, 1'b0, 5'd0, '0, ZR, ZR, "R6 zero reg after write", 1'b1);
    step(1'b0, 1'b0, 5'd0, '0, 5'd1, 5'd2, "R6 neighbours untouched", 1'b1);
    // R7: disabled write leaves target alone.
    step(1'b0, 1'b0, 5'd3, 32'hDEAD_BEEF, 5'd3, 5'd5, "R7 disabled write", 1'b1);
    step(1'b0, 1'b0, 5'd5, 32'hDEAD_BEEF, 5'd3, 5'd5, "R7 target unchanged", 1'b1);
    // R8: write during reset blocked, contents retained.
    step(1'b1, 1'b1, 5'd9, 32'h5555_AAAA, ZR, 5'd9, "R5 R8 in reset", 1'b1);
    step(1'b1, 1'b1, 5'd10, 32'h5555_AAAA, 5'd10, 5'd9, "R8 in reset", 1'b1);
    step(1'b0, 1'b0, 5'd0, '0, 5'd9, 5'd10, "R8 retained after reset", 1'b1);
    // R1: walking-one patterns into one register.
    for (int b = 0; b < 32; b++) begin
      step(1'b0, 1'b1, 5'd12, 32'd1 << b, 5'd11, 5'd13, "R1 walking write", 1'b1);
      step(1'b0, 1'b0, 5'd0, '0, 5'd12, 5'd12, "R1 walking readback", 1'b1);
    end
    step(1'b0, 1'b0, 5'd0, '0, ZR, ZR, "R5 final", 1'b0);
    @(negedge clk);
    #3;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule